// File: doc/BRIEF.md
# Three-Bank Prioritized Interrupt Controller

This block collects 96 level-sensitive interrupt lines, grouped in three banks of 32. It drives two request outputs to a processor: a normal path and a fast path. Each line carries a configuration word that sets a 6-bit priority and sends the line to either the normal or the fast path. For each path, a priority arbiter picks one winner among the lines that are pending and unmasked. When that path is armed and the global mask is clear, the arbiter latches the winner's code and raises the path's request. The request and the code then stay frozen until software rearms that path.

Software reaches the block through a 32-bit word-addressed register window of 4 KB. The bank registers are spread across the address space at a fixed stride. Each bank has a raw input view, a mask register, atomic set and clear aliases for the mask, and atomic set and clear aliases for software-forced interrupts. Each bank also has two pending views, one per path. Global registers hold the revision, a reset-done status, autoidle and soft reset, the two winner codes, the control register, and two idle-control bits.

Top module: `irq_ctrl3`

## Requirements
- R1: After reset, both requests are low, every bank mask reads 0xFFFFFFFF, and byte offset 0x000 reads 0x21. Offset 0x014 reads 1 and offset 0x048 reads 0.
- R2: Offset 0x80+0x20*b+0x00 reads bank b's sampled input levels. A rising input sets its pending bit. Any falling input in a bank rewrites that whole bank's pending word to (inputs OR software bits).
- R3: The mask of bank b is at 0x80+0x20*b+0x04 and is written directly. Writing +0x08 clears the mask bits set in the value, and writing +0x0C sets them. Both aliases read 0.
- R4: Writing +0x10 ORs the value into both the software bits and pending, and +0x10 reads back the software bits. Writing +0x14 clears those software bits and then sets pending to (software bits AND inputs). +0x14 reads 0.
- R5: +0x18 reads pending AND NOT mask AND NOT fast-select. +0x1C reads pending AND NOT mask AND fast-select.
- R6: The word for global line n is at 0x100+4*n. Bits 7:2 hold the priority and bit 0 holds the fast-select; a read returns these fields with all other bits 0.
- R7: On each path, the winner is the eligible line with the smallest priority value, and a tie goes to the highest line number. Offset 0x040 reads the normal winner code and 0x044 reads the fast one.
- R8: A path raises its request when it is armed, at least one line is eligible, and the global mask is clear. The request then stays high and its code stays frozen until software writes the path's rearm bit, even if the line is later masked.
- R9: Control register 0x048: bit 2 is the global mask, bit 1 rearms the fast path and bit 0 rearms the normal path. While the global mask is set, no request is raised. A read returns only bit 2.
- R10: Offset 0x010 bit 0 is a readable autoidle bit, and writing a 1 to bit 1 performs a full soft reset. Offset 0x050 holds two readable idle bits.
- R11: Bank slot 3 (0x0E0 to 0x0FF) reads 0 and ignores writes. Offset 0x04C reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | 96 | Level interrupt inputs, line n on bit n |
| bus_valid_i | input | 1 | Access strobe, one cycle per word |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_waddr_i | input | 10 | Word address (byte offset divided by 4) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered, valid the cycle after the read strobe |
| irq_normal_o | output | 1 | Normal-path request |
| irq_fast_o | output | 1 | Fast-path request |

## Verification
The assertions run on every cycle. They check that a raised request and its code hold until a rearm, and that no request rises while the global mask was set or without an eligible line. They also check that the mask-set and mask-clear aliases and the software-set write take effect on the next cycle. Only the bench scenarios can show which line wins a priority tie and how pending bits behave after input falls and software-clear writes. The same holds for soft-reset recovery with live inputs and for the inert fourth bank slot. The bench compares all of these against a reference model driven by random and directed traffic.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int unsigned WORD_W = 32;

   typedef enum logic [2:0] {
      BR_RAW  = 3'd0,
      BR_MASK = 3'd1,
      BR_MCLR = 3'd2,
      BR_MSET = 3'd3,
      BR_SSET = 3'd4,
      BR_SCLR = 3'd5,
      BR_PNRM = 3'd6,
      BR_PFST = 3'd7
   } bank_reg_e;

   typedef struct packed {
      logic mask_wr;
      logic mclr_wr;
      logic mset_wr;
      logic sset_wr;
      logic sclr_wr;
   } bank_wr_t;

   localparam logic [11:0] OFS_REV     = 12'h000;
   localparam logic [11:0] OFS_SYSCFG  = 12'h010;
   localparam logic [11:0] OFS_SYSSTAT = 12'h014;
   localparam logic [11:0] OFS_CODE_N  = 12'h040;
   localparam logic [11:0] OFS_CODE_F  = 12'h044;
   localparam logic [11:0] OFS_CTRL    = 12'h048;
   localparam logic [11:0] OFS_PROT    = 12'h04C;
   localparam logic [11:0] OFS_IDLE    = 12'h050;
   localparam logic [11:0] OFS_LINE    = 12'h100;
   localparam logic [7:0]  REV_VALUE   = 8'h21;
endpackage

// File: rtl/intc_bank.sv
module intc_bank
   import intc_pkg::*;
#(
   parameter int unsigned LINES = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic [LINES-1:0] lines_i,
   input  bank_wr_t         wr_i,
   input  logic [LINES-1:0] wdata_i,
   output logic [LINES-1:0] raw_o,
   output logic [LINES-1:0] mask_o,
   output logic [LINES-1:0] swi_o,
   output logic [LINES-1:0] pend_o
);
   logic [LINES-1:0] in_q, mask_q, swi_q, pend_q;
   logic [LINES-1:0] rise, fall, swi_n, pend_n, mask_n;

   assign rise = lines_i & ~in_q;
   assign fall = ~lines_i & in_q;

   always_comb begin
      swi_n  = swi_q;
      mask_n = mask_q;
      if (|fall) pend_n = lines_i | swi_q;
      else       pend_n = pend_q | rise;
      if (wr_i.mask_wr) mask_n = wdata_i;
      if (wr_i.mclr_wr) mask_n = mask_q & ~wdata_i;
      if (wr_i.mset_wr) mask_n = mask_q | wdata_i;
      if (wr_i.sset_wr) begin
         swi_n  = swi_q | wdata_i;
         pend_n = pend_n | wdata_i;
      end
      if (wr_i.sclr_wr) begin
         swi_n  = swi_q & ~wdata_i;
         pend_n = swi_n & lines_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q   <= '0;
         mask_q <= '1;
         swi_q  <= '0;
         pend_q <= '0;
      end else if (soft_rst) begin
         in_q   <= '0;
         mask_q <= '1;
         swi_q  <= '0;
         pend_q <= '0;
      end else begin
         in_q   <= lines_i;
         mask_q <= mask_n;
         swi_q  <= swi_n;
         pend_q <= pend_n;
      end
   end

   assign raw_o  = in_q;
   assign mask_o = mask_q;
   assign swi_o  = swi_q;
   assign pend_o = pend_q;

   AST_MASK_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i.mset_wr && !soft_rst) |=> ((mask_o & $past(wdata_i)) == $past(wdata_i))); // R3
   AST_MASK_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i.mclr_wr && !soft_rst) |=> ((mask_o & $past(wdata_i)) == '0)); // R3
   AST_SWI_SET_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i.sset_wr && !wr_i.sclr_wr && !soft_rst) |=> ((pend_o & $past(wdata_i)) == $past(wdata_i))); // R4
endmodule

// File: rtl/intc_line_cfg.sv
module intc_line_cfg #(
   parameter int unsigned NLINES = 96,
   parameter int unsigned PRIO_W = 6,
   localparam int unsigned IDX_W = $clog2(NLINES)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           soft_rst,
   input  logic                           wr_en,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [PRIO_W-1:0]              wr_prio,
   input  logic                           wr_fsel,
   output logic [NLINES-1:0][PRIO_W-1:0]  prio_o,
   output logic [NLINES-1:0]              fsel_o
);
   for (genvar n = 0; n < NLINES; n++) begin : g_line
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(n));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prio_o[n] <= '0;
            fsel_o[n] <= 1'b0;
         end else if (soft_rst) begin
            prio_o[n] <= '0;
            fsel_o[n] <= 1'b0;
         end else if (hit) begin
            prio_o[n] <= wr_prio;
            fsel_o[n] <= wr_fsel;
         end
      end
   end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
   parameter int unsigned NLINES = 96,
   parameter int unsigned PRIO_W = 6,
   parameter bit          FAST   = 1'b0,
   localparam int unsigned CODE_W = $clog2(NLINES)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          soft_rst,
   input  logic [NLINES-1:0]             pend_i,
   input  logic [NLINES-1:0]             mask_i,
   input  logic [NLINES-1:0]             fsel_i,
   input  logic [NLINES-1:0][PRIO_W-1:0] prio_i,
   input  logic                          gmask_i,
   input  logic                          rearm_i,
   output logic                          req_o,
   output logic [CODE_W-1:0]             code_o
);
   logic [NLINES-1:0] active;
   logic              armed_q;
   logic              found;
   logic [PRIO_W-1:0] best_p;
   logic [CODE_W-1:0] best_i;
   logic              fire;

   if (FAST) begin : g_fast
      assign active = pend_i & ~mask_i & fsel_i;
   end else begin : g_norm
      assign active = pend_i & ~mask_i & ~fsel_i;
   end

   always_comb begin
      found  = 1'b0;
      best_p = '1;
      best_i = '0;
      for (int i = 0; i < NLINES; i++) begin
         if (active[i] && (!found || prio_i[i] <= best_p)) begin
            found  = 1'b1;
            best_p = prio_i[i];
            best_i = CODE_W'(i);
         end
      end
   end

   assign fire = armed_q && found && !gmask_i && !rearm_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         req_o   <= 1'b0;
         code_o  <= '0;
      end else if (soft_rst) begin
         armed_q <= 1'b1;
         req_o   <= 1'b0;
         code_o  <= '0;
      end else if (rearm_i) begin
         armed_q <= 1'b1;
         req_o   <= 1'b0;
      end else if (fire) begin
         armed_q <= 1'b0;
         req_o   <= 1'b1;
         code_o  <= best_i;
      end
   end

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !rearm_i && !soft_rst) |=> req_o); // R8
   AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !rearm_i && !soft_rst) |=> $stable(code_o)); // R8
   AST_NO_RAISE_GMASK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_o) |-> $past(!gmask_i)); // R9
   AST_RAISE_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_o) |-> $past(|active)); // R8
endmodule

// File: rtl/irq_ctrl3.sv
module irq_ctrl3
   import intc_pkg::*;
#(
   parameter int unsigned NUM_BANKS  = 3,
   parameter int unsigned BANK_LINES = 32,
   parameter int unsigned PRIO_W     = 6,
   parameter int unsigned ADDR_W     = 12,
   localparam int unsigned NLINES    = NUM_BANKS * BANK_LINES,
   localparam int unsigned CODE_W    = $clog2(NLINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] irq_lines_i,
   input  logic              bus_valid_i,
   input  logic              bus_write_i,
   input  logic [ADDR_W-3:0] bus_waddr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   output logic              irq_normal_o,
   output logic              irq_fast_o
);
   initial begin
      assert (BANK_LINES == WORD_W) else $error("bank width must equal the word width");
      assert (NUM_BANKS >= 1 && NUM_BANKS <= 4) else $error("bank count out of range");
      assert (PRIO_W >= 1 && PRIO_W <= 6) else $error("priority field must fit bits 7:2");
      assert (ADDR_W == 12) else $error("window must be 4 KB");
   end

   logic [ADDR_W-1:0] baddr;
   logic              wr, rd;
   logic              in_bank_win, bank_ok, in_line;
   logic [1:0]        bank_sel;
   logic [1:0]        bidx;
   bank_reg_e         breg;
   logic [ADDR_W-1:0] line_off;
   logic [CODE_W-1:0] line_idx;

   assign baddr       = {bus_waddr_i, 2'b00};
   assign wr          = bus_valid_i && bus_write_i;
   assign rd          = bus_valid_i && !bus_write_i;
   assign in_bank_win = (baddr[ADDR_W-1:7] == (ADDR_W-7)'(1));
   assign bank_sel    = baddr[6:5];
   assign bank_ok     = (32'(bank_sel) < NUM_BANKS);
   assign bidx        = bank_ok ? bank_sel : 2'd0;
   assign breg        = bank_reg_e'(baddr[4:2]);
   assign line_off    = baddr - OFS_LINE;
   assign in_line     = (baddr >= OFS_LINE) && (32'(line_off) < 4 * NLINES);
   assign line_idx    = line_off[CODE_W+1:2];

   // global control state
   logic       soft_rst;
   logic       gmask_q, autoidle_q;
   logic [1:0] idle_q;
   logic       rearm_n, rearm_f;
   logic       ctrl_wr;

   assign ctrl_wr  = wr && (baddr == OFS_CTRL);
   assign soft_rst = wr && (baddr == OFS_SYSCFG) && bus_wdata_i[1];
   assign rearm_n  = ctrl_wr && bus_wdata_i[0];
   assign rearm_f  = ctrl_wr && bus_wdata_i[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gmask_q    <= 1'b0;
         autoidle_q <= 1'b0;
         idle_q     <= '0;
      end else if (soft_rst) begin
         gmask_q    <= 1'b0;
         autoidle_q <= 1'b0;
         idle_q     <= '0;
      end else begin
         if (ctrl_wr) gmask_q <= bus_wdata_i[2];
         if (wr && baddr == OFS_SYSCFG) autoidle_q <= bus_wdata_i[0];
         if (wr && baddr == OFS_IDLE) idle_q <= bus_wdata_i[1:0];
      end
   end

   // banks
   logic [NUM_BANKS-1:0][BANK_LINES-1:0] raw_b, mask_b, swi_b, pend_b;
   logic [NLINES-1:0]                    pend_f, mask_f, fsel_f;
   logic [NLINES-1:0][PRIO_W-1:0]        prio_f;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic     hit;
      bank_wr_t bw;
      assign hit        = wr && in_bank_win && (bank_sel == 2'(b));
      assign bw.mask_wr = hit && (breg == BR_MASK);
      assign bw.mclr_wr = hit && (breg == BR_MCLR);
      assign bw.mset_wr = hit && (breg == BR_MSET);
      assign bw.sset_wr = hit && (breg == BR_SSET);
      assign bw.sclr_wr = hit && (breg == BR_SCLR);

      intc_bank #(.LINES(BANK_LINES)) i_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .soft_rst (soft_rst),
         .lines_i  (irq_lines_i[b*BANK_LINES +: BANK_LINES]),
         .wr_i     (bw),
         .wdata_i  (bus_wdata_i),
         .raw_o    (raw_b[b]),
         .mask_o   (mask_b[b]),
         .swi_o    (swi_b[b]),
         .pend_o   (pend_b[b])
      );
      assign pend_f[b*BANK_LINES +: BANK_LINES] = pend_b[b];
      assign mask_f[b*BANK_LINES +: BANK_LINES] = mask_b[b];
   end

   intc_line_cfg #(.NLINES(NLINES), .PRIO_W(PRIO_W)) i_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .wr_en    (wr && in_line),
      .wr_idx   (line_idx),
      .wr_prio  (bus_wdata_i[PRIO_W+1:2]),
      .wr_fsel  (bus_wdata_i[0]),
      .prio_o   (prio_f),
      .fsel_o   (fsel_f)
   );

   logic [CODE_W-1:0] code_n, code_f;

   intc_arbiter #(.NLINES(NLINES), .PRIO_W(PRIO_W), .FAST(1'b0)) i_arb_norm (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .pend_i   (pend_f),
      .mask_i   (mask_f),
      .fsel_i   (fsel_f),
      .prio_i   (prio_f),
      .gmask_i  (gmask_q),
      .rearm_i  (rearm_n),
      .req_o    (irq_normal_o),
      .code_o   (code_n)
   );

   intc_arbiter #(.NLINES(NLINES), .PRIO_W(PRIO_W), .FAST(1'b1)) i_arb_fast (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .pend_i   (pend_f),
      .mask_i   (mask_f),
      .fsel_i   (fsel_f),
      .prio_i   (prio_f),
      .gmask_i  (gmask_q),
      .rearm_i  (rearm_f),
      .req_o    (irq_fast_o),
      .code_o   (code_f)
   );

   // read path
   logic [31:0]           rd_next;
   logic [BANK_LINES-1:0] fsel_sel;

   assign fsel_sel = fsel_f[32'(bidx)*BANK_LINES +: BANK_LINES];

   always_comb begin
      rd_next = '0;
      if (in_bank_win) begin
         if (bank_ok) begin
            unique case (breg)
               BR_RAW:  rd_next = raw_b[bidx];
               BR_MASK: rd_next = mask_b[bidx];
               BR_SSET: rd_next = swi_b[bidx];
               BR_PNRM: rd_next = pend_b[bidx] & ~mask_b[bidx] & ~fsel_sel;
               BR_PFST: rd_next = pend_b[bidx] & ~mask_b[bidx] & fsel_sel;
               default: rd_next = '0;
            endcase
         end
      end else if (in_line) begin
         rd_next = 32'({prio_f[line_idx], 1'b0, fsel_f[line_idx]});
      end else begin
         case (baddr)
            OFS_REV:     rd_next = 32'(REV_VALUE);
            OFS_SYSCFG:  rd_next = 32'(autoidle_q);
            OFS_SYSSTAT: rd_next = 32'd1;
            OFS_CODE_N:  rd_next = 32'(code_n);
            OFS_CODE_F:  rd_next = 32'(code_f);
            OFS_CTRL:    rd_next = {29'd0, gmask_q, 2'b00};
            OFS_IDLE:    rd_next = 32'(idle_q);
            default:     rd_next = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bus_rdata_o <= '0;
      else if (rd) bus_rdata_o <= rd_next;
   end

   AST_RESET_REQS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!irq_normal_o && !irq_fast_o)); // R10
endmodule

// File: tb/test_irq_ctrl3.sv
module test_irq_ctrl3;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [95:0] lines = '0;
   logic        valid = 1'b0, write = 1'b0;
   logic [9:0]  waddr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_n, irq_f;

   always #2 clk = ~clk;

   irq_ctrl3 i_irq_ctrl3 (
      .clk(clk), .rst_n(rst_n), .irq_lines_i(lines),
      .bus_valid_i(valid), .bus_write_i(write), .bus_waddr_i(waddr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .irq_normal_o(irq_n), .irq_fast_o(irq_f)
   );

   int checks = 0, fails = 0;
   bit done = 0;

   // reference model
   bit [31:0] m_in[3], m_mask[3], m_swi[3], m_pend[3];
   int        m_prio[96];
   bit        m_fsel[96];
   bit        m_armed[2], m_req[2];
   int        m_code[2];
   bit        m_gm, m_auto;
   bit [1:0]  m_idle;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic void m_apply_lines(logic [95:0] v);
      for (int b = 0; b < 3; b++) begin
         bit [31:0] nw, rise, fall;
         nw   = v[b*32 +: 32];
         rise = nw & ~m_in[b];
         fall = m_in[b] & ~nw;
         if (fall != 0) m_pend[b] = nw | m_swi[b];
         else           m_pend[b] = m_pend[b] | rise;
         m_in[b] = nw;
      end
   endfunction

   function automatic void m_reset();
      for (int b = 0; b < 3; b++) begin
         m_in[b] = 0; m_mask[b] = '1; m_swi[b] = 0; m_pend[b] = 0;
      end
      for (int n = 0; n < 96; n++) begin m_prio[n] = 0; m_fsel[n] = 0; end
      for (int p = 0; p < 2; p++) begin m_armed[p] = 1; m_req[p] = 0; m_code[p] = 0; end
      m_gm = 0; m_auto = 0; m_idle = 0;
   endfunction

   function automatic void m_eval();
      for (int p = 0; p < 2; p++) begin
         int best_p, best_i;
         bit found;
         found = 0; best_p = 0; best_i = 0;
         for (int n = 0; n < 96; n++) begin
            bit act;
            act = m_pend[n/32][n%32] && !m_mask[n/32][n%32] && (m_fsel[n] == bit'(p));
            if (act && (!found || m_prio[n] <= best_p)) begin
               found = 1; best_p = m_prio[n]; best_i = n;
            end
         end
         if (m_armed[p] && found && !m_gm) begin
            m_armed[p] = 0; m_req[p] = 1; m_code[p] = best_i;
         end
      end
   endfunction

   function automatic void m_write(int a, bit [31:0] v);
      if (a >= 'h80 && a < 'h100) begin
         int b, r;
         b = (a - 'h80) / 32; r = (a % 32) / 4;
         if (b < 3) begin
            case (r)
               1: m_mask[b] = v;
               2: m_mask[b] = m_mask[b] & ~v;
               3: m_mask[b] = m_mask[b] | v;
               4: begin m_swi[b] = m_swi[b] | v; m_pend[b] = m_pend[b] | v; end
               5: begin m_swi[b] = m_swi[b] & ~v; m_pend[b] = m_swi[b] & m_in[b]; end
               default: ;
            endcase
         end
      end else if (a >= 'h100 && a < 'h100 + 4*96) begin
         m_prio[(a - 'h100)/4] = int'(v[7:2]);
         m_fsel[(a - 'h100)/4] = v[0];
      end else if (a == 'h10) begin
         m_auto = v[0];
         if (v[1]) m_reset();
      end else if (a == 'h48) begin
         m_gm = v[2];
         if (v[1]) begin m_req[1] = 0; m_armed[1] = 1; end
         if (v[0]) begin m_req[0] = 0; m_armed[0] = 1; end
      end else if (a == 'h50) begin
         m_idle = v[1:0];
      end
   endfunction

   function automatic bit [31:0] m_read(int a);
      if (a >= 'h80 && a < 'h100) begin
         int b, r;
         bit [31:0] fs;
         b = (a - 'h80) / 32; r = (a % 32) / 4;
         if (b >= 3) return 0;
         for (int i = 0; i < 32; i++) fs[i] = m_fsel[b*32+i];
         case (r)
            0: return m_in[b];
            1: return m_mask[b];
            4: return m_swi[b];
            6: return m_pend[b] & ~m_mask[b] & ~fs;
            7: return m_pend[b] & ~m_mask[b] & fs;
            default: return 0;
         endcase
      end
      if (a >= 'h100 && a < 'h100 + 4*96)
         return (32'(m_prio[(a-'h100)/4]) << 2) | 32'(m_fsel[(a-'h100)/4]);
      case (a)
         'h00: return 32'h21;
         'h10: return 32'(m_auto);
         'h14: return 1;
         'h40: return 32'(m_code[0]);
         'h44: return 32'(m_code[1]);
         'h48: return {29'd0, m_gm, 2'b00};
         'h50: return 32'(m_idle);
         default: return 0;
      endcase
   endfunction

   task automatic settle();
      repeat (3) @(negedge clk);
      m_eval();
   endtask

   task automatic op_wr(int a, bit [31:0] v);
      @(negedge clk);
      valid = 1; write = 1; waddr = 10'(a >> 2); wdata = v;
      @(negedge clk);
      valid = 0; write = 0;
      m_write(a, v);
      if (a == 'h10 && v[1]) m_apply_lines(lines);
      settle();
   endtask

   task automatic op_lines(logic [95:0] v);
      @(negedge clk);
      lines = v;
      m_apply_lines(v);
      settle();
   endtask

   task automatic bus_rd(int a, output logic [31:0] d);
      @(negedge clk);
      valid = 1; write = 0; waddr = 10'(a >> 2);
      @(negedge clk);
      valid = 0;
      d = rdata;
   endtask

   task automatic chk_rd(string req, int a);
      logic [31:0] d;
      bus_rd(a, d);
      check(req, d, m_read(a));
   endtask

   task automatic chk_reqs(string req);
      check(req, {31'd0, irq_n}, {31'd0, m_req[0]});
      check(req, {31'd0, irq_f}, {31'd0, m_req[1]});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'h1234_5678));
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      check("R1 req", {30'd0, irq_n, irq_f}, 32'd0);
      bus_rd('h00, d); check("R1 revision", d, 32'h21);
      bus_rd('h14, d); check("R1 status", d, 32'd1);
      bus_rd('h48, d); check("R1 control", d, 32'd0);
      for (int b = 0; b < 3; b++) begin
         bus_rd('h84 + 32*b, d); check("R1 mask", d, 32'hFFFF_FFFF);
      end

      // R11 bank slot 3 and protection offset
      op_wr('hE4, 32'h0); op_wr('hF0, 32'hFFFF_FFFF);
      bus_rd('hE4, d); check("R11 bank3 read", d, 0);
      bus_rd('hF0, d); check("R11 bank3 swi", d, 0);
      op_wr('h4C, 32'h1);
      bus_rd('h4C, d); check("R11 protection", d, 0);
      for (int b = 0; b < 3; b++) chk_rd("R11 masks kept", 'h84 + 32*b);
      chk_reqs("R11 no request");

      // R7 tie to highest line, then lower value wins after rearm
      op_wr('h84, 32'h0);
      op_lines(96'h408);
      check("R8 normal raised", {31'd0, irq_n}, 1);
      bus_rd('h40, d); check("R7 tie highest line", d, 32'd10);
      op_wr('h100 + 4*3, 32'h4);
      op_wr('h100 + 4*10, 32'h8);
      bus_rd('h40, d); check("R8 code frozen", d, 32'd10);
      op_wr('h84, 32'hFFFF_FFFF);
      check("R8 held after mask", {31'd0, irq_n}, 1);
      op_wr('h84, 32'h0);
      op_wr('h48, 32'h1);
      bus_rd('h40, d); check("R7 lowest value wins", d, 32'd3);
      chk_reqs("R8 rearm");

      // R9 global mask
      op_wr('h48, 32'h5);
      check("R9 blocked", {31'd0, irq_n}, 0);
      bus_rd('h48, d); check("R9 read only bit2", d, 32'h4);
      op_wr('h48, 32'h0);
      check("R9 raised after clear", {31'd0, irq_n}, 1);

      // R5 fast path
      op_wr('h100 + 4*40, 32'h1);
      op_wr('hA8, 32'h0000_0100);
      op_lines(lines | (96'h1 << 40));
      check("R5 fast raised", {31'd0, irq_f}, 1);
      bus_rd('h44, d); check("R7 fast code", d, 32'd40);
      chk_rd("R5 pending fast", 'hBC);
      chk_rd("R5 pending normal", 'hB8);
      chk_rd("R6 line word", 'h100 + 4*40);

      // R4 software clear recomputes pending from inputs
      op_lines(96'h20);
      op_wr('h90, 32'h80);
      chk_rd("R4 swi readback", 'h90);
      op_wr('h94, 32'h80);
      bus_rd('h98, d); check("R4 pending after swi clear", d, 32'h0);
      chk_rd("R4 clear alias", 'h94);
      chk_rd("R3 clear alias", 'h88);
      chk_rd("R3 set alias", 'h8C);
      chk_rd("R2 raw", 'h80);

      // R10 autoidle, idle bits, soft reset
      op_wr('h10, 32'h1);
      bus_rd('h10, d); check("R10 autoidle", d, 1);
      op_wr('h50, 32'h3);
      bus_rd('h50, d); check("R10 idle bits", d, 3);
      op_wr('h10, 32'h2);
      bus_rd('h10, d); check("R10 soft reset autoidle", d, 0);
      bus_rd('h84, d); check("R10 soft reset mask", d, 32'hFFFF_FFFF);
      bus_rd('h50, d); check("R10 soft reset idle", d, 0);
      chk_reqs("R10 soft reset reqs");

      // random traffic checked against the model
      for (int it = 0; it < 600; it++) begin
         int op, b;
         op = int'($urandom % 9);
         b  = int'($urandom % 4);
         case (op)
            0, 1: begin
               logic [95:0] v;
               v = lines ^ ({$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom});
               op_lines(v);
            end
            2: op_wr('h84 + 32*b, $urandom & $urandom);
            3: op_wr('h88 + 32*b, $urandom);
            4: op_wr('h8C + 32*b, $urandom & $urandom);
            5: op_wr('h90 + 32*b, $urandom & $urandom & $urandom);
            6: op_wr('h94 + 32*b, $urandom);
            7: op_wr('h100 + 4*int'($urandom % 96), ($urandom % 4) << 2 | ($urandom % 2));
            default: op_wr('h48, ($urandom % 8 == 0) ? 32'h4 : 32'($urandom % 4));
         endcase
         chk_reqs("R8 random requests");
         if (it % 3 == 0) chk_rd("R7 random normal code", 'h40);
         if (it % 3 == 1) chk_rd("R7 random fast code", 'h44);
         if (it % 3 == 2) chk_rd("R5 random bank view", 'h80 + 32*b + 4*int'($urandom % 8));
      end
      if (m_gm) op_wr('h48, 32'h0);
      chk_rd("R2 final raw", 'h80);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule